// File: doc/BRIEF.md
# Control-Structure Pointer Load Validator

This block performs the checking and state update for the privileged instruction that loads the current control-structure pointer in a core with hardware virtualization. A start pulse is sampled together with the core's mode bits, its privilege level, a segment-fault flag and a 64-bit operand address. The block works through a fixed order of checks. First come the conditions that make the opcode undefined. Next is the exit taken in guest (non-root) operation, then privilege and segment faults, then the operand address checks. The last check before memory compares the operand against the stored enable-region pointer.

When every early check passes, the block fetches one 32-bit word from the operand address over a request/valid read port. It then checks that word against the configured revision identifier and the shadowing-support setting. It reports one 3-bit result code that is valid for exactly one cycle. The current-pointer register and its valid bit change only on success.

The configuration inputs are the physical-address width, the revision identifier, the shadowing-support bit and the 32-bit address limit. They are static and are captured at start. Result codes: 0 success, 1 bad address, 2 operand equals enable-region pointer, 3 wrong revision, 4 undefined-opcode fault, 5 general-protection fault, 6 exit to the hypervisor.

Top module: `csp_load_check`

## Requirements
- R1: At start, code 4 (undefined opcode) is reported when any of these hold: the operand is a register, virtualization is off, protection is disabled, virtual-8086 mode is on, or long mode is active while the code segment is not a 64-bit segment. This check has the highest priority.
- R2: If R1 passes and `nonroot` is 1, code 6 (exit) is reported, whatever the privilege level or segment fault.
- R3: After that, code 5 (general protection) is reported when `cpl` is nonzero or `seg_fault` is 1.
- R4: After that, an operand with any of address bits 11:0 set gives code 1.
- R5: Code 1 is also reported when any operand bit at position `pa_width` or above is 1. When `lim32` is 1, any set bit in 63:32 also gives code 1. A `pa_width` of 64 allows every bit.
- R6: When all address checks pass and the operand equals `enable_ptr`, code 2 is reported. An operand that is both equal and badly formed gives code 1.
- R7: A read is issued only when R1 to R6 all pass. `rd_req` holds with `rd_addr` equal to the operand until `rd_valid` is seen. No read is issued otherwise.
- R8: The read word gives code 3 when its bits 30:0 differ from `rev_id`, or when its bit 31 is 1 and `shadow_ok` is 0. Bit 31 set with `shadow_ok` 1 is accepted.
- R9: On success, code 0 is reported, `cur_ptr` takes the operand and `cur_ptr_vld` becomes 1 in the cycle the result is valid.
- R10: On any other code, `cur_ptr` and `cur_ptr_vld` keep their previous values.
- R11: `res_valid` is high for exactly one cycle. For checks that do not need memory it comes the cycle after start; on the read path it comes the cycle after `rd_valid`. `busy` is high in the start cycle and while the read is pending. A start while an operation is in flight is ignored.
- R12: A synchronous active-high `rst` clears `cur_ptr_vld`, `cur_ptr`, `busy`, `res_valid` and `rd_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one load operation (accepted when idle) |
| op_is_reg | input | 1 | Operand is a register rather than memory |
| virt_on | input | 1 | Core is in virtualization operation |
| prot_en | input | 1 | Protection enabled |
| v86 | input | 1 | Virtual-8086 mode |
| lma | input | 1 | Long mode active |
| cs_long | input | 1 | Code segment is a 64-bit segment |
| nonroot | input | 1 | Core runs as a guest |
| cpl | input | 2 | Current privilege level |
| seg_fault | input | 1 | Operand segment limit or unusable segment |
| op_addr | input | 64 | Operand (new pointer) address |
| pa_width | input | 7 | Physical-address width, 1 to 64 |
| rev_id | input | 31 | Expected revision identifier |
| shadow_ok | input | 1 | Shadowing supported |
| lim32 | input | 1 | Restrict addresses to 32 bits |
| enable_ptr | input | 64 | Stored enable-region pointer |
| rd_req | output | 1 | Memory read request |
| rd_addr | output | 64 | Memory read address |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 32 | Read data |
| busy | output | 1 | Operation in progress |
| res_valid | output | 1 | Result valid (one cycle) |
| res_code | output | 3 | Result code |
| cur_ptr | output | 64 | Current pointer |
| cur_ptr_vld | output | 1 | Current pointer valid |

## Verification
The bench goes after the priority edges. It sets two fault conditions together, for example guest mode with a nonzero privilege level, or an operand that equals the enable pointer and also has a bit beyond the address width. A design with the chain in the wrong order would report the lower-priority code, or would issue a read it should have blocked. It also tests the address limit at its edges: a bit exactly at `pa_width`, a width of 64, and the 32-bit limit. A shift or mask that is off by one lets a bad address through, or rejects a good one. The revision word is tried with bit 31 set under both shadowing settings and with a single low-bit mismatch, so a comparison that takes in bit 31 or drops a bit is caught. A start pulse during a slow read confirms that a design which restarts mid-operation or corrupts the held address is exposed. The pointer is compared every cycle after failures, so any design that writes it before all checks pass is caught.

// File: rtl/csp_load_check.sv
module csp_load_check #(
  parameter int AW = 64,
  parameter int DW = 32,
  parameter int PAGE_BITS = 12,
  parameter int CPL_W = 2,
  localparam int PW = $clog2(AW) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          op_is_reg,
  input  logic          virt_on,
  input  logic          prot_en,
  input  logic          v86,
  input  logic          lma,
  input  logic          cs_long,
  input  logic          nonroot,
  input  logic [CPL_W-1:0] cpl,
  input  logic          seg_fault,
  input  logic [AW-1:0] op_addr,
  input  logic [PW-1:0] pa_width,
  input  logic [DW-2:0] rev_id,
  input  logic          shadow_ok,
  input  logic          lim32,
  input  logic [AW-1:0] enable_ptr,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_valid,
  input  logic [DW-1:0] rd_data,
  output logic          busy,
  output logic          res_valid,
  output logic [2:0]    res_code,
  output logic [AW-1:0] cur_ptr,
  output logic          cur_ptr_vld
);
  localparam logic [2:0] C_OK = 3'd0, C_ADDR = 3'd1, C_ENPTR = 3'd2, C_REV = 3'd3,
                         C_UD = 3'd4, C_GP = 3'd5, C_EXIT = 3'd6;

  typedef enum logic [1:0] {S_IDLE, S_READ, S_DONE} st_t;
  st_t st;

  logic [2:0]    code_q;
  logic [DW-2:0] rev_q;
  logic          shadow_q;
  logic [2:0]    pre_code;
  logic          pre_ok;

  wire is_ud    = op_is_reg | ~virt_on | ~prot_en | v86 | (lma & ~cs_long);
  wire bad_addr = (|op_addr[PAGE_BITS-1:0]) | ((op_addr >> pa_width) != '0)
                | (lim32 & (|op_addr[AW-1:32]));
  wire rev_bad  = (rd_data[DW-2:0] != rev_q) | (rd_data[DW-1] & ~shadow_q);

  always_comb begin
    pre_ok   = 1'b0;
    pre_code = C_OK;
    if (is_ud)                         pre_code = C_UD;
    else if (nonroot)                  pre_code = C_EXIT;
    else if (cpl != '0 || seg_fault)   pre_code = C_GP;
    else if (bad_addr)                 pre_code = C_ADDR;
    else if (op_addr == enable_ptr)    pre_code = C_ENPTR;
    else                               pre_ok   = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_IDLE;
      code_q      <= C_OK;
      rd_addr     <= '0;
      rev_q       <= '0;
      shadow_q    <= 1'b0;
      cur_ptr     <= '0;
      cur_ptr_vld <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          rd_addr  <= op_addr;
          rev_q    <= rev_id;
          shadow_q <= shadow_ok;
          code_q   <= pre_code;
          st       <= pre_ok ? S_READ : S_DONE;
        end
        S_READ: if (rd_valid) begin
          st <= S_DONE;
          if (rev_bad) code_q <= C_REV;
          else begin
            code_q      <= C_OK;
            cur_ptr     <= rd_addr;
            cur_ptr_vld <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign rd_req    = (st == S_READ);
  assign res_valid = (st == S_DONE);
  assign res_code  = code_q;
  assign busy      = (st == S_READ) | ((st == S_IDLE) & start);

  a_r7_aligned_read: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> rd_addr[PAGE_BITS-1:0] == '0);
  a_r7_req_held: assert property (@(posedge clk) disable iff (rst)
    rd_req && !rd_valid |=> rd_req && $stable(rd_addr));
  a_r10_ptr_only_on_ok: assert property (@(posedge clk) disable iff (rst)
    !($stable(cur_ptr) && $stable(cur_ptr_vld)) |-> res_valid && res_code == C_OK);
  a_r9_ok_sets_ptr: assert property (@(posedge clk) disable iff (rst)
    res_valid && res_code == C_OK |-> cur_ptr_vld && cur_ptr == rd_addr);
  a_r11_one_cycle: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);
  a_r11_not_busy_at_result: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> !busy && !rd_req);
endmodule

// File: tb/test_csp_load_check.sv
module test_csp_load_check;
  logic clk = 0, rst = 1, start = 0;
  logic op_is_reg, virt_on, prot_en, v86, lma, cs_long, nonroot, seg_fault, shadow_ok, lim32;
  logic [1:0] cpl;
  logic [63:0] op_addr, enable_ptr;
  logic [6:0] pa_width;
  logic [30:0] rev_id;
  logic rd_valid = 0;
  logic [31:0] rd_data = 0;
  logic rd_req, busy, res_valid, cur_ptr_vld;
  logic [63:0] rd_addr, cur_ptr;
  logic [2:0] res_code;

  int checks = 0, fails = 0, cyc = 0;
  int lat = 0, lcnt = 0;
  logic [31:0] mem_word = 0;

  int m_st = 0, m_code = 0;
  logic [63:0] m_addr = 0, m_ptr = 0;
  logic m_vld = 0, m_sh = 0;
  logic [30:0] m_rev = 0;

  always #4 clk = ~clk;

  csp_load_check i_csp_load_check (
    .clk(clk), .rst(rst), .start(start), .op_is_reg(op_is_reg), .virt_on(virt_on),
    .prot_en(prot_en), .v86(v86), .lma(lma), .cs_long(cs_long), .nonroot(nonroot),
    .cpl(cpl), .seg_fault(seg_fault), .op_addr(op_addr), .pa_width(pa_width),
    .rev_id(rev_id), .shadow_ok(shadow_ok), .lim32(lim32), .enable_ptr(enable_ptr),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .busy(busy), .res_valid(res_valid), .res_code(res_code), .cur_ptr(cur_ptr),
    .cur_ptr_vld(cur_ptr_vld));

  function automatic int ref_pre();
    bit bad = 0;
    if (op_is_reg || !virt_on || !prot_en || v86 || (lma && !cs_long)) return 4;
    if (nonroot) return 6;
    if (cpl != 0 || seg_fault) return 5;
    for (int i = 0; i < 64; i++) begin
      if (i < 12 && op_addr[i]) bad = 1;
      if (i >= int'(pa_width) && op_addr[i]) bad = 1;
      if (lim32 && i >= 32 && op_addr[i]) bad = 1;
    end
    if (bad) return 1;
    if (op_addr == enable_ptr) return 2;
    return 0;
  endfunction

  function automatic string tag_of(int c);
    case (c)
      0: return "R9"; 1: return "R4/R5"; 2: return "R6"; 3: return "R8";
      4: return "R1"; 5: return "R3"; default: return "R2";
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_vld = 0; m_ptr = 0; m_code = 0;
    end else begin
      case (m_st)
        0: if (start) begin
          m_code = ref_pre();
          m_addr = op_addr; m_rev = rev_id; m_sh = shadow_ok;
          m_st = (m_code == 0) ? 1 : 2;
        end
        1: if (rd_valid) begin
          if (rd_data[30:0] != m_rev || (rd_data[31] && !m_sh)) m_code = 3;
          else begin m_code = 0; m_ptr = m_addr; m_vld = 1; end
          m_st = 2;
        end
        default: m_st = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rd_req && !rd_valid) begin
      if (lcnt >= lat) begin rd_valid <= 1; rd_data <= mem_word; lcnt = 0; end
      else lcnt++;
    end else rd_valid <= 0;
  end

  task automatic chk(string r, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h at cycle %0d", r, what, act, exp, cyc);
    end
  endtask

  always begin
    @(negedge clk); #2;
    cyc++;
    chk(rst ? "R12" : "R11", "res_valid", 64'(res_valid), 64'(m_st == 2));
    chk(rst ? "R12" : "R11", "busy", 64'(busy), 64'(m_st == 1 || (m_st == 0 && start && !rst)));
    chk(rst ? "R12" : "R7", "rd_req", 64'(rd_req), 64'(m_st == 1));
    if (m_st == 1) chk("R7", "rd_addr", rd_addr, m_addr);
    if (m_st == 2) chk(tag_of(m_code), "res_code", 64'(res_code), 64'(m_code));
    chk(rst ? "R12" : "R10", "cur_ptr_vld", 64'(cur_ptr_vld), 64'(m_vld));
    chk(rst ? "R12" : "R10", "cur_ptr", cur_ptr, m_ptr);
  end

  task automatic finish_up();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) if (cyc > 100000) begin
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  task automatic defaults();
    op_is_reg = 0; virt_on = 1; prot_en = 1; v86 = 0; lma = 1; cs_long = 1;
    nonroot = 0; cpl = 0; seg_fault = 0; pa_width = 7'd46; shadow_ok = 0; lim32 = 0;
    rev_id = 31'h0000_0A5C; enable_ptr = 64'h0000_0000_0010_0000;
    op_addr = 64'h0000_0012_3456_7000; mem_word = {1'b0, 31'h0000_0A5C}; lat = 1;
  endtask

  task automatic run_op(bit pulse_mid = 0);
    int n = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    if (pulse_mid) begin
      @(negedge clk); start = 1;
      @(negedge clk); start = 0;
    end
    while (!res_valid && n < 50) begin @(negedge clk); n++; end
    @(negedge clk); @(negedge clk);
    defaults();
  endtask

  initial begin
    defaults();
    repeat (3) @(negedge clk);
    rst = 0;
    // R9 success
    run_op();
    // R1 each undefined-opcode cause
    op_is_reg = 1; run_op();
    virt_on = 0; run_op();
    prot_en = 0; run_op();
    v86 = 1; run_op();
    cs_long = 0; run_op();
    lma = 0; cs_long = 0; op_addr = 64'h2000; lat = 0; run_op();
    // R2 exit beats privilege
    nonroot = 1; cpl = 3; run_op();
    nonroot = 1; op_addr = 64'h1; run_op();
    // R3
    cpl = 1; run_op();
    seg_fault = 1; run_op();
    cpl = 2; op_addr = 64'h3; run_op();
    // R4
    op_addr = 64'h0000_0000_0040_0800; run_op();
    // R5 width edges
    pa_width = 7'd39; op_addr = 64'h0000_0080_0000_0000; run_op();
    pa_width = 7'd39; op_addr = 64'h0000_0040_0000_0000; run_op();
    pa_width = 7'd64; op_addr = 64'h8000_0000_0000_1000; lat = 3; run_op();
    lim32 = 1; pa_width = 7'd52; op_addr = 64'h0000_0002_0000_0000; run_op();
    lim32 = 0; pa_width = 7'd52; op_addr = 64'h0000_0002_0000_0000; run_op();
    lim32 = 1; op_addr = 64'h0000_0000_FFFF_F000; run_op();
    // R6
    op_addr = enable_ptr; run_op();
    pa_width = 7'd20; op_addr = 64'h0000_0000_0010_0000; enable_ptr = op_addr; run_op();
    // R8
    mem_word = {1'b0, 31'h0000_0A5D}; run_op();
    mem_word = {1'b1, 31'h0000_0A5C}; run_op();
    shadow_ok = 1; mem_word = {1'b1, 31'h0000_0A5C}; op_addr = 64'h7000; run_op();
    mem_word = {1'b0, 31'h4000_0A5C}; lat = 2; run_op();
    // R11 start during pending read ignored
    lat = 4; op_addr = 64'h0000_0000_0ABC_D000; run_op(1);
    // R10 failure after success keeps pointer
    cpl = 3; run_op();
    // R12 reset clears valid
    @(negedge clk); rst = 1; @(negedge clk); @(negedge clk); rst = 0;
    run_op();
    repeat (3) @(negedge clk);
    finish_up();
  end
endmodule